// File: doc/BRIEF.md
# Complementary Output Stage with Dead Time and Idle Levels

This block is the drive stage for one timer channel that owns a main output and a complementary output. It takes a reference waveform from a compare generator outside the block. When the master output enable is high, the main output follows the reference and the complementary output follows its inverse. A programmable dead interval is inserted at every reference edge, so the two outputs are never both active across a switch. When the master output enable drops, both outputs go inactive for the dead interval. After that, each output settles to an idle level chosen by software.

The enable and polarity bits come through a two-stage scheme: a preload copy and an active copy. With preloading off, the active copy tracks the preload copy. With preloading on, the active copy changes only on a commutation strobe, or optionally on a rising edge of a trigger input as well. The idle levels sit behind a write-protection level. That level can be set once after reset and then stays fixed until the next reset.

A five-state machine sequences the outputs:

- `ST_IDLE` drives the idle levels.
- `ST_IDLE_DT` counts the dead interval before the idle levels apply.
- `ST_DEAD` counts the dead interval between active phases.
- `ST_MAIN_ON` drives the main output active.
- `ST_COMP_ON` drives the complementary output active.

The transitions are named as follows:

- **arm** goes from `ST_IDLE` or `ST_IDLE_DT` to `ST_DEAD` when the enable rises. When the dead count is zero it goes straight to the on-state that matches the reference.
- **settle** goes from `ST_DEAD` to `ST_MAIN_ON` or `ST_COMP_ON` when the count expires.
- **swap** goes from an on-state to `ST_DEAD` on a reference edge. When the count is zero it goes straight to the other on-state.
- **retrigger** stays in `ST_DEAD` and reloads the count when the reference changes during a dead interval.
- **rest** goes from any running state to `ST_IDLE_DT` when the enable falls. When the count is zero it goes straight to `ST_IDLE`.
- **park** goes from `ST_IDLE_DT` to `ST_IDLE` when the count expires.

Top module: `comp_out_stage`

## Requirements
- R1: After reset both outputs are 0, the idle levels are 0, the protection level is 0 and the active control copy is all zero.
- R2: With preload off (`preload_en_i`=0), the active control copy takes the value of `ctl_pre_i` at every clock edge. The bit positions are [0] main enable, [1] complementary enable, [2] main polarity, [3] complementary polarity.
- R3: With preload on and `upd_sel_i`=0, the active control copy loads from `ctl_pre_i` only at an edge where `com_strobe_i` is 1. A trigger rising edge has no effect.
- R4: With preload on and `upd_sel_i`=1, the active control copy loads on `com_strobe_i`, or on a trigger rising edge. A rising edge means `trig_i` is 1 at this edge and was 0 at the previous edge. A trigger held high causes no further loads.
- R5: While running, the main raw signal is active in the main on-state and the complementary raw signal is active in the complementary on-state. An enabled output drives raw XOR polarity. A disabled output drives 0.
- R6: A reference edge while running makes both outputs inactive (raw 0) for `dt_i` clock cycles before the new on-state. When `dt_i`=0 the new on-state follows at the next edge with no gap.
- R7: A reference edge during a dead interval reloads the count, so the dead interval restarts from that edge.
- R8: A falling master output enable makes both outputs inactive for `dt_i` cycles. After that, `out_main_o` drives idle bit [0] and `out_comp_o` drives idle bit [1], with polarity not applied.
- R9: `idle_wr_i` updates the idle levels only while the protection level is 0.
- R10: `lock_wr_i` updates the protection level only while it is 0. Once the level is non-zero, it cannot be lowered or changed until reset.
- R11: A rising master output enable from idle passes through a dead interval of `dt_i` cycles before the on-state that matches the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference waveform |
| moe_i | input | 1 | Master output enable |
| dt_i | input | DT_W | Dead interval in clock cycles |
| ctl_pre_i | input | 4 | Preload copy of the enable and polarity bits |
| preload_en_i | input | 1 | Preload mode for the control bits |
| upd_sel_i | input | 1 | Also accept a trigger rising edge as a load event |
| com_strobe_i | input | 1 | Commutation strobe |
| trig_i | input | 1 | Trigger input |
| idle_wr_i | input | 1 | Write strobe for the idle levels |
| idle_d_i | input | 2 | Idle levels: [0] main, [1] complementary |
| lock_wr_i | input | 1 | Write strobe for the protection level |
| lock_d_i | input | LOCK_W | New protection level |
| out_main_o | output | 1 | Main output |
| out_comp_o | output | 1 | Complementary output |

## Verification
The bench targets these corner cases, each paired with the failure it catches:

- **Dead interval on a reference edge.** Both outputs are counted through the exact dead window on a reference edge, on an enable rise and on an enable fall. A counter that is off by one shows an output one cycle early or late.
- **Reference reversal during the dead interval.** The reference flips back partway through a dead interval. A design that does not restart the count turns the main output on too soon.
- **Load gating by the trigger.** The trigger is raised under strobe-only mode, and later held high under strobe-or-trigger mode. A design that decodes levels rather than edges, or that ignores the update select, loads the control copy at the wrong time.
- **Protection level.** The level is written once and then given a lower value. A design that lets that write through accepts a later idle write, and the idle output changes.

// File: rtl/cos_pkg.sv
package cos_pkg;

    // Active/preload control word; bit 0 is the main enable.
    typedef struct packed {
        logic pol_comp;
        logic pol_main;
        logic en_comp;
        logic en_main;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
    localparam int NOUT  = 2;      // index 0: main, index 1: complementary

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_IDLE_DT = 3'd1,
        ST_DEAD    = 3'd2,
        ST_MAIN_ON = 3'd3,
        ST_COMP_ON = 3'd4
    } phase_e;

endpackage

// File: rtl/cos_ctl_bank.sv
module cos_ctl_bank
    import cos_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ctl_t pre_i,
    input  logic preload_en_i,
    input  logic upd_sel_i,
    input  logic com_strobe_i,
    input  logic trig_i,
    output ctl_t act_o
);

    ctl_t act_q;
    logic trig_q;
    logic trig_rise;
    logic load;

    // Trigger edge counts only when preloading is on.
    assign trig_rise = preload_en_i & trig_i & ~trig_q;
    assign load      = ~preload_en_i | com_strobe_i | (upd_sel_i & trig_rise);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            act_q  <= '0;
        end else begin
            trig_q <= trig_i;
            if (load) begin
                act_q <= pre_i;
            end
        end
    end

    assign act_o = act_q;

    AST_CTL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !preload_en_i |=> act_q == $past(pre_i)); // R2

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en_i && !com_strobe_i && !(upd_sel_i && trig_i && !trig_q))
        |=> $stable(act_q)); // R3

    AST_CTL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en_i && com_strobe_i) |=> act_q == $past(pre_i)); // R3

    AST_CTL_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en_i && upd_sel_i && trig_i && !trig_q) |=> act_q == $past(pre_i)); // R4

endmodule

// File: rtl/cos_prot_regs.sv
module cos_prot_regs
    import cos_pkg::*;
#(
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_wr_i,
    input  logic [NOUT-1:0]   idle_d_i,
    input  logic              lock_wr_i,
    input  logic [LOCK_W-1:0] lock_d_i,
    output logic [NOUT-1:0]   idle_o
);

    logic [NOUT-1:0]   idle_q;
    logic [LOCK_W-1:0] lock_q;
    logic              open_w;

    assign open_w = (lock_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
            lock_q <= '0;
        end else begin
            if (idle_wr_i && open_w) begin
                idle_q <= idle_d_i;
            end
            if (lock_wr_i && open_w) begin
                lock_q <= lock_d_i;
            end
        end
    end

    assign idle_o = idle_q;

    AST_IDLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != '0) |=> $stable(idle_q)); // R9

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != '0) |=> $stable(lock_q)); // R10

endmodule

// File: rtl/cos_dt_fsm.sv
module cos_dt_fsm
    import cos_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_i,
    input  logic            moe_i,
    input  logic [DT_W-1:0] dt_i,
    output logic            raw_main_o,
    output logic            raw_comp_o,
    output logic            idle_sel_o
);

    localparam logic [DT_W-1:0] ONE = DT_W'(1);

    phase_e          state_q, state_n;
    logic [DT_W-1:0] cnt_q, cnt_n;
    logic            ref_q;
    logic            ref_edge;
    logic            dt_zero;
    phase_e          on_st;
    phase_e          arm_st;
    phase_e          rest_st;

    assign ref_edge = ref_i ^ ref_q;
    assign dt_zero  = (dt_i == '0);
    assign on_st    = ref_i ? ST_MAIN_ON : ST_COMP_ON;
    assign arm_st   = dt_zero ? on_st : ST_DEAD;
    assign rest_st  = dt_zero ? ST_IDLE : ST_IDLE_DT;

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ref_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            ref_q   <= ref_i;
        end
    end

    // Transition process.
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (moe_i) begin                       // arm
                    state_n = arm_st;
                    cnt_n   = dt_i;
                end
            end
            ST_IDLE_DT: begin
                if (moe_i) begin                       // arm
                    state_n = arm_st;
                    cnt_n   = dt_i;
                end else if (cnt_q <= ONE) begin       // park
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q - ONE;
                end
            end
            ST_DEAD: begin
                if (!moe_i) begin                      // rest
                    state_n = rest_st;
                    cnt_n   = dt_i;
                end else if (ref_edge) begin           // retrigger
                    state_n = arm_st;
                    cnt_n   = dt_i;
                end else if (cnt_q <= ONE) begin       // settle
                    state_n = on_st;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q - ONE;
                end
            end
            ST_MAIN_ON, ST_COMP_ON: begin
                if (!moe_i) begin                      // rest
                    state_n = rest_st;
                    cnt_n   = dt_i;
                end else if (ref_edge) begin           // swap
                    state_n = arm_st;
                    cnt_n   = dt_i;
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // Output process.
    always_comb begin
        raw_main_o = 1'b0;
        raw_comp_o = 1'b0;
        idle_sel_o = 1'b0;
        unique case (state_q)
            ST_MAIN_ON: raw_main_o = 1'b1;
            ST_COMP_ON: raw_comp_o = 1'b1;
            ST_IDLE:    idle_sel_o = 1'b1;
            default: ;
        endcase
    end

    AST_ON_MATCHES_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAIN_ON) |-> ref_q); // R5

    AST_COMP_MATCHES_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMP_ON) |-> !ref_q); // R5

    AST_SWAP_HAS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_MAIN_ON || state_q == ST_COMP_ON) && moe_i && ref_edge && !dt_zero)
        |=> state_q == ST_DEAD); // R6

    AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEAD || state_q == ST_IDLE_DT) |-> cnt_q != '0); // R7

    AST_MOE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !moe_i |=> !(state_q == ST_MAIN_ON || state_q == ST_COMP_ON)); // R8

    AST_ARM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && moe_i && !dt_zero) |=> state_q == ST_DEAD); // R11

endmodule

// File: rtl/cos_out_mux.sv
module cos_out_mux
    import cos_pkg::*;
(
    input  ctl_t            act_i,
    input  logic            raw_main_i,
    input  logic            raw_comp_i,
    input  logic            idle_sel_i,
    input  logic [NOUT-1:0] idle_i,
    output logic [NOUT-1:0] out_o
);

    logic [NOUT-1:0] en_v;
    logic [NOUT-1:0] pol_v;
    logic [NOUT-1:0] raw_v;

    assign en_v  = {act_i.en_comp,  act_i.en_main};
    assign pol_v = {act_i.pol_comp, act_i.pol_main};
    assign raw_v = {raw_comp_i,     raw_main_i};

    for (genvar g = 0; g < NOUT; g++) begin : g_drv
        always_comb begin
            if (idle_sel_i) begin
                out_o[g] = idle_i[g];
            end else if (en_v[g]) begin
                out_o[g] = raw_v[g] ^ pol_v[g];
            end else begin
                out_o[g] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/comp_out_stage.sv
module comp_out_stage
    import cos_pkg::*;
#(
    parameter int DT_W   = 8,
    parameter int LOCK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_i,
    input  logic              moe_i,
    input  logic [DT_W-1:0]   dt_i,
    input  logic [CTL_W-1:0]  ctl_pre_i,
    input  logic              preload_en_i,
    input  logic              upd_sel_i,
    input  logic              com_strobe_i,
    input  logic              trig_i,
    input  logic              idle_wr_i,
    input  logic [NOUT-1:0]   idle_d_i,
    input  logic              lock_wr_i,
    input  logic [LOCK_W-1:0] lock_d_i,
    output logic              out_main_o,
    output logic              out_comp_o
);

    ctl_t            act_w;
    logic [NOUT-1:0] idle_w;
    logic [NOUT-1:0] out_w;
    logic            raw_main_w;
    logic            raw_comp_w;
    logic            idle_sel_w;

    cos_ctl_bank u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pre_i        (ctl_t'(ctl_pre_i)),
        .preload_en_i (preload_en_i),
        .upd_sel_i    (upd_sel_i),
        .com_strobe_i (com_strobe_i),
        .trig_i       (trig_i),
        .act_o        (act_w)
    );

    cos_prot_regs #(.LOCK_W(LOCK_W)) u_prot (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle_wr_i (idle_wr_i),
        .idle_d_i  (idle_d_i),
        .lock_wr_i (lock_wr_i),
        .lock_d_i  (lock_d_i),
        .idle_o    (idle_w)
    );

    cos_dt_fsm #(.DT_W(DT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_i      (ref_i),
        .moe_i      (moe_i),
        .dt_i       (dt_i),
        .raw_main_o (raw_main_w),
        .raw_comp_o (raw_comp_w),
        .idle_sel_o (idle_sel_w)
    );

    cos_out_mux u_mux (
        .act_i      (act_w),
        .raw_main_i (raw_main_w),
        .raw_comp_i (raw_comp_w),
        .idle_sel_i (idle_sel_w),
        .idle_i     (idle_w),
        .out_o      (out_w)
    );

    assign out_main_o = out_w[0];
    assign out_comp_o = out_w[1];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!out_main_o && !out_comp_o)); // R1

endmodule

// File: tb/tb_comp_out_stage.sv
`timescale 1ns/1ps
module tb_comp_out_stage;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ref_i, moe_i, preload_en_i, upd_sel_i, com_strobe_i, trig_i;
    logic [7:0] dt_i;
    logic [3:0] ctl_pre_i;
    logic       idle_wr_i, lock_wr_i;
    logic [1:0] idle_d_i, lock_d_i;
    logic       out_main_o, out_comp_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    comp_out_stage dut (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .moe_i(moe_i), .dt_i(dt_i),
        .ctl_pre_i(ctl_pre_i), .preload_en_i(preload_en_i), .upd_sel_i(upd_sel_i),
        .com_strobe_i(com_strobe_i), .trig_i(trig_i), .idle_wr_i(idle_wr_i),
        .idle_d_i(idle_d_i), .lock_wr_i(lock_wr_i), .lock_d_i(lock_d_i),
        .out_main_o(out_main_o), .out_comp_o(out_comp_o)
    );

    // {ctl[3:0], ref, expected main, expected comp}; preload off, dead time 0 (R2, R5)
    localparam logic [6:0] VEC [8] = '{
        7'b0011_1_10, 7'b0011_0_01, 7'b0111_1_00, 7'b1011_0_00,
        7'b1011_1_11, 7'b0001_0_00, 7'b0010_0_01, 7'b1110_1_01
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [1:0] exp);
        logic [1:0] act;
        act = {out_main_o, out_comp_o};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual={main,comp}=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        rst_n = 1'b0; ref_i = 0; moe_i = 0; dt_i = 0; ctl_pre_i = 0;
        preload_en_i = 0; upd_sel_i = 0; com_strobe_i = 0; trig_i = 0;
        idle_wr_i = 0; idle_d_i = 0; lock_wr_i = 0; lock_d_i = 0;
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1 reset", 2'b00);

        // Vector table
        moe_i = 1'b1;
        step(1);
        for (int i = 0; i < 8; i++) begin
            ctl_pre_i = VEC[i][6:3];
            ref_i     = VEC[i][2];
            step(2);
            check($sformatf("R5/R2 vector %0d", i), VEC[i][1:0]);
        end

        // Idle write while unlocked
        moe_i = 1'b0; ctl_pre_i = 4'b0011;
        step(1);
        idle_wr_i = 1'b1; idle_d_i = 2'b10;
        step(1);
        idle_wr_i = 1'b0;
        check("R9 idle write open", 2'b01);

        // Enable rise with dead time 3
        dt_i = 8'd3; ref_i = 1'b0;
        step(1);
        moe_i = 1'b1;
        step(1);
        check("R11 arm dead first", 2'b00);
        step(2);
        check("R11 arm dead last", 2'b00);
        step(1);
        check("R11 arm settle comp", 2'b01);

        // Reference edge
        ref_i = 1'b1;
        step(3);
        check("R6 swap dead", 2'b00);
        step(1);
        check("R6 swap main on", 2'b10);

        // Retrigger during dead interval
        ref_i = 1'b0;
        step(2);
        ref_i = 1'b1;
        step(3);
        check("R7 retrigger still dead", 2'b00);
        step(1);
        check("R7 retrigger main on", 2'b10);

        // Enable fall
        moe_i = 1'b0;
        step(3);
        check("R8 rest dead", 2'b00);
        step(1);
        check("R8 idle levels", 2'b01);

        // Protection level
        lock_wr_i = 1'b1; lock_d_i = 2'd2;
        step(1);
        lock_wr_i = 1'b0;
        idle_wr_i = 1'b1; idle_d_i = 2'b01;
        step(1);
        idle_wr_i = 1'b0;
        check("R9 idle write locked", 2'b01);
        lock_wr_i = 1'b1; lock_d_i = 2'd0;
        step(1);
        lock_wr_i = 1'b0;
        idle_wr_i = 1'b1; idle_d_i = 2'b01;
        step(1);
        idle_wr_i = 1'b0;
        check("R10 lock not lowered", 2'b01);

        // Preloaded control, strobe only
        dt_i = 8'd0; moe_i = 1'b1; ref_i = 1'b1; ctl_pre_i = 4'b0011;
        step(2);
        check("R2 running main", 2'b10);
        preload_en_i = 1'b1; upd_sel_i = 1'b0; ctl_pre_i = 4'b0111;
        step(2);
        check("R3 held without strobe", 2'b10);
        trig_i = 1'b1;
        step(1);
        trig_i = 1'b0;
        step(1);
        check("R3 trigger ignored", 2'b10);
        com_strobe_i = 1'b1;
        step(1);
        com_strobe_i = 1'b0;
        check("R3 strobe loads", 2'b00);

        // Preloaded control, strobe or trigger
        upd_sel_i = 1'b1; ctl_pre_i = 4'b0011;
        step(1);
        check("R4 no event", 2'b00);
        trig_i = 1'b1;
        step(1);
        check("R4 trigger rise loads", 2'b10);
        ctl_pre_i = 4'b0111;
        step(3);
        check("R4 held trigger ignored", 2'b10);
        trig_i = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule